// File: doc/BRIEF.md
# Character Clock Generator

This block turns a master dot clock into the character-rate timing that a CRT timing controller counts to place its horizontal and vertical sync. It runs a counter of dots inside a character cell and produces three outputs. `cclk_en` is a one-clock pulse on the last dot of each cell. `dot_idx` is the position of the current dot inside the cell. `dot_en` marks the master clocks that carry a dot. A cell is either 8 or 9 dots wide. The dot rate can also be halved for low-resolution modes, in which case a dot lasts two master clocks.

Software programs the block through an index/data port pair. A write on the index port selects a register. A write on the data port loads the selected register, and `rd_data` always shows its contents. One register holds a halt control that freezes the sequence while timing is reprogrammed. A second register holds the cell-width and halving controls. A mode written while the sequence runs is copied into the active mode only at a cell boundary or while halted. This means no cell ever has a mixed width.

A two-state machine controls the sequence:
- **HOLD** is entered from reset, or from RUN when the halt bit is set (transition *halt*). In HOLD the counters stay at zero and the active mode follows the programmed mode.
- **RUN** is entered from HOLD when the halt bit is clear (transition *release*). It leaves for HOLD on *halt*.

Top module: `chrclk_gen`

## Requirements
- R1: While `rst_n` is low, `dot_idx` is 0, `dot_en` and `cclk_en` are 0, and `rd_data` reads 0. All registers reset to 0, so after reset the block runs in 8-dot, full-rate mode.
- R2: Register access works as follows:
  - An `idx_we` write stores `wdata` as the index.
  - A `data_we` write loads the selected register, and `rd_data` shows the selected register.
  - Index 0 holds the halt control in bit 1.
  - Index 1 holds nine-dot cells in bit 0 and dot-rate halving in bit 3.
  - All other bits read 0. Any other index reads 0, and writes to it change nothing.
- R3: In 8-dot mode, `dot_idx` steps 0 to 7 and wraps to 0. `cclk_en` is high exactly in the clock where `dot_idx` is 7 and `dot_en` is high.
- R4: In 9-dot mode, `dot_idx` steps 0 to 8. `cclk_en` is high exactly in the clock where `dot_idx` is 8 and `dot_en` is high.
- R5: At full rate, `dot_en` is high on every running clock. With halving, `dot_en` is high on alternate clocks, starting low on the first running clock. `dot_idx` advances only after clocks with `dot_en` high.
- R6: From the second clock after the write edge that sets halt, `dot_en` and `cclk_en` stay 0 and `dot_idx` stays 0.
- R7: A mode write made while running leaves the cell in progress at its old width. The new width applies from the next cell on.
- R8: After the write edge that clears halt, the state enters RUN at the next edge. The first running clock shows `dot_idx` 0, and the first `cclk_en` follows a complete cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Write `wdata` to the index port |
| data_we | input | 1 | Write `wdata` to the selected register |
| wdata | input | 8 | Write data for both ports |
| rd_data | output | 8 | Contents of the selected register |
| cclk_en | output | 1 | Character clock enable, one clock per cell |
| dot_en | output | 1 | High on clocks that carry a dot |
| dot_idx | output | 4 | Dot position within the cell |

## Verification
Four corner cases are targeted:
- **Mode change mid-cell.** The bench writes nine-dot mode in the middle of an 8-dot cell. A design that applies the mode at once would stretch that cell to 9 dots or emit an early pulse.
- **Restart after halt.** The bench checks the first running clocks after halt is cleared. A design that keeps the old dot count, or drops the halving phase, shows a nonzero `dot_idx` or a `dot_en` in the wrong phase.
- **All four width and rate combinations.** Each is compared clock by clock against an independent model. This catches an off-by-one wrap or a pulse on the wrong dot.
- **Unmapped index writes.** Writes to an unmapped index are checked for leaving the real registers untouched.

// File: rtl/chrclk_pkg.sv
package chrclk_pkg;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    localparam int CELL_NARROW = 8;
    localparam int CELL_WIDE   = 9;

    localparam int IDX_CTRL = 0;
    localparam int IDX_MODE = 1;

    localparam int HALT_BIT = 1;
    localparam int NINE_BIT = 0;
    localparam int HALF_BIT = 3;

endpackage

// File: rtl/chrclk_regs.sv
module chrclk_regs
    import chrclk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic              data_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              cfg_halt,
    output logic              cfg_nine,
    output logic              cfg_half
);

    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(1) << HALT_BIT;
    localparam logic [DATA_W-1:0] MODE_MASK = (DATA_W'(1) << NINE_BIT) | (DATA_W'(1) << HALF_BIT);

    logic [DATA_W-1:0] idx_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] mode_q;
    logic              sel_ctrl;
    logic              sel_mode;

    assign sel_ctrl = (idx_q == DATA_W'(IDX_CTRL));
    assign sel_mode = (idx_q == DATA_W'(IDX_MODE));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ctrl_q <= '0;
            mode_q <= '0;
        end else begin
            if (idx_we) begin
                idx_q <= wdata;
            end
            if (data_we && sel_ctrl) begin
                ctrl_q <= wdata & CTRL_MASK;
            end
            if (data_we && sel_mode) begin
                mode_q <= wdata & MODE_MASK;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (sel_ctrl) begin
            rd_data = ctrl_q;
        end else if (sel_mode) begin
            rd_data = mode_q;
        end
    end

    assign cfg_halt = ctrl_q[HALT_BIT];
    assign cfg_nine = mode_q[NINE_BIT];
    assign cfg_half = mode_q[HALF_BIT];

    // R2: a data write aimed at an unmapped index leaves both registers alone
    p_unmapped_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !idx_we && idx_q > DATA_W'(IDX_MODE)) |=> ($stable(ctrl_q) && $stable(mode_q)));

endmodule

// File: rtl/chrclk_seq_fsm.sv
module chrclk_seq_fsm
    import chrclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_halt,
    input  logic cfg_nine,
    input  logic cfg_half,
    input  logic cclk_en,
    output logic run,
    output logic nine_act,
    output logic half_act
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       mode_load;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (!cfg_halt) state_d = ST_RUN;
            ST_RUN:  if (cfg_halt)  state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        run       = 1'b0;
        mode_load = 1'b1;
        unique case (state_q)
            ST_HOLD: begin
                run       = 1'b0;
                mode_load = 1'b1;
            end
            ST_RUN: begin
                run       = 1'b1;
                mode_load = cclk_en;
            end
        endcase
    end

    // active mode, swapped only at a cell boundary or while holding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nine_act <= 1'b0;
            half_act <= 1'b0;
        end else if (mode_load) begin
            nine_act <= cfg_nine;
            half_act <= cfg_half;
        end
    end

    // R7: the active width changes only after a cell end or a held clock
    p_width_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_act != $past(nine_act)) |-> $past(cclk_en || state_q == ST_HOLD));

    // R7: the same rule for the rate
    p_rate_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (half_act != $past(half_act)) |-> $past(cclk_en || state_q == ST_HOLD));

endmodule

// File: rtl/chrclk_dot_ctr.sv
module chrclk_dot_ctr
    import chrclk_pkg::*;
#(
    parameter int DOT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             nine_act,
    input  logic             half_act,
    output logic             dot_en,
    output logic             cclk_en,
    output logic [DOT_W-1:0] dot_idx
);

    localparam logic [DOT_W-1:0] LAST_NARROW = DOT_W'(CELL_NARROW - 1);
    localparam logic [DOT_W-1:0] LAST_WIDE   = DOT_W'(CELL_WIDE - 1);

    logic phase_q;
    logic last_dot;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= 1'b0;
        end else if (half_act) begin
            phase_q <= ~phase_q;
        end else begin
            phase_q <= 1'b0;
        end
    end

    assign dot_en   = run && (!half_act || phase_q);
    assign last_dot = (dot_idx == (nine_act ? LAST_WIDE : LAST_NARROW));
    assign cclk_en  = dot_en && last_dot;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dot_idx <= '0;
        end else if (dot_en) begin
            dot_idx <= last_dot ? '0 : dot_idx + 1'b1;
        end
    end

    // R3: a character pulse is always followed by dot 0
    p_wrap_after_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_en |=> (dot_idx == '0));

    // R4: the index never passes the last dot of the active width
    p_idx_in_cell_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nine_act ? (dot_idx <= LAST_WIDE) : (dot_idx <= LAST_NARROW));

    // R5: at half rate a dot inside a cell is followed by an empty clock
    p_half_alternates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (half_act && dot_en && !cclk_en) |=> !dot_en);

    // R6: a second held clock shows a zero index and no pulse
    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> (dot_idx == '0 && !cclk_en));

    // R8: entering the running state starts at dot 0
    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (dot_idx == '0));

endmodule

// File: rtl/chrclk_gen.sv
module chrclk_gen
    import chrclk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DOT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic              data_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              cclk_en,
    output logic              dot_en,
    output logic [DOT_W-1:0]  dot_idx
);

    logic cfg_halt;
    logic cfg_nine;
    logic cfg_half;
    logic run;
    logic nine_act;
    logic half_act;

    chrclk_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_we   (idx_we),
        .data_we  (data_we),
        .wdata    (wdata),
        .rd_data  (rd_data),
        .cfg_halt (cfg_halt),
        .cfg_nine (cfg_nine),
        .cfg_half (cfg_half)
    );

    chrclk_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_halt (cfg_halt),
        .cfg_nine (cfg_nine),
        .cfg_half (cfg_half),
        .cclk_en  (cclk_en),
        .run      (run),
        .nine_act (nine_act),
        .half_act (half_act)
    );

    chrclk_dot_ctr #(.DOT_W(DOT_W)) u_dots (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .nine_act (nine_act),
        .half_act (half_act),
        .dot_en   (dot_en),
        .cclk_en  (cclk_en),
        .dot_idx  (dot_idx)
    );

    // R1: nothing moves while reset is held
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (dot_idx == '0));

    // R5: a character pulse only lands on a dot clock
    p_pulse_on_dot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_en |-> dot_en);

endmodule

// File: tb/tb_chrclk_gen.sv
`timescale 1ns/1ps
module tb_chrclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_we = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic       cclk_en;
    logic       dot_en;
    logic [3:0] dot_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chrclk_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_we  (idx_we),
        .data_we (data_we),
        .wdata   (wdata),
        .rd_data (rd_data),
        .cclk_en (cclk_en),
        .dot_en  (dot_en),
        .dot_idx (dot_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // register write: index, then data; returns at the negedge after the data edge
    task automatic wr(input int idx, input int val);
        @(negedge clk);
        idx_we = 1'b1; wdata = 8'(idx);
        @(negedge clk);
        idx_we = 1'b0; data_we = 1'b1; wdata = 8'(val);
        @(negedge clk);
        data_we = 1'b0; wdata = '0;
    endtask

    task automatic sel(input int idx);
        @(negedge clk);
        idx_we = 1'b1; wdata = 8'(idx);
        @(negedge clk);
        idx_we = 1'b0; wdata = '0;
    endtask

    // independent model: k counts running clocks from the first one
    task automatic model(input int k, input bit nine, input bit half,
                         output int idx, output int den, output int cc);
        int w;
        int cnt;
        w   = nine ? 9 : 8;
        den = half ? (k % 2) : 1;
        cnt = half ? k / 2 : k;
        idx = cnt % w;
        cc  = (den == 1 && idx == w - 1) ? 1 : 0;
    endtask

    task automatic cmp_cycle(input string req, input int k, input bit nine, input bit half);
        int ei, ed, ec;
        model(k, nine, half, ei, ed, ec);
        chk({req, " dot_idx"}, int'(dot_idx), ei);
        chk({req, " dot_en"}, int'(dot_en), ed);
        chk({req, " cclk_en"}, int'(cclk_en), ec);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 dot_idx", int'(dot_idx), 0);
        chk("R1 dot_en", int'(dot_en), 0);
        chk("R1 cclk_en", int'(cclk_en), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_regs();
        wr(1, 8'hFF);
        chk("R2 mode readback", int'(rd_data), 8'h09);
        wr(1, 8'h00);
        chk("R2 mode clear", int'(rd_data), 0);
        wr(0, 8'hFF);
        chk("R2 ctrl readback", int'(rd_data), 8'h02);
        wr(0, 8'h00);
        chk("R2 ctrl clear", int'(rd_data), 0);
    endtask

    task automatic t_unmapped();
        wr(1, 8'h08);
        wr(5, 8'hFF);
        chk("R2 unmapped reads zero", int'(rd_data), 0);
        sel(1);
        chk("R2 mode untouched", int'(rd_data), 8'h08);
        sel(0);
        chk("R2 ctrl untouched", int'(rd_data), 0);
        wr(1, 8'h00);
    endtask

    // halt, program, release, then compare two cells clock by clock
    task automatic t_pattern(input string req, input bit nine, input bit half);
        int n;
        wr(0, 8'h02);
        wr(1, (half ? 8'h08 : 8'h00) | (nine ? 8'h01 : 8'h00));
        wr(0, 8'h00);
        n = 2 * (nine ? 9 : 8) * (half ? 2 : 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cmp_cycle(req, k, nine, half);
        end
    endtask

    task automatic t_halt();
        wr(0, 8'h00);
        repeat (5) @(negedge clk);
        wr(0, 8'h02);
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R6 hold dot_idx", int'(dot_idx), 0);
            chk("R6 hold dot_en", int'(dot_en), 0);
            chk("R6 hold cclk_en", int'(cclk_en), 0);
        end
    endtask

    // R8: first running clocks after release, full rate, 8 dots
    task automatic t_release();
        wr(0, 8'h02);
        wr(1, 8'h00);
        wr(0, 8'h00);
        chk("R8 still held", int'(dot_en), 0);
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            cmp_cycle("R8", k, 1'b0, 1'b0);
        end
    endtask

    // R7: switch to nine dots in the middle of an 8-dot cell
    task automatic t_midcell();
        int ei, ec;
        wr(0, 8'h02);
        wr(1, 8'h00);
        wr(0, 8'h00);
        @(negedge clk);
        chk("R7 k0 dot_idx", int'(dot_idx), 0);
        idx_we = 1'b1; wdata = 8'h01;
        @(negedge clk);
        chk("R7 k1 dot_idx", int'(dot_idx), 1);
        idx_we = 1'b0; data_we = 1'b1; wdata = 8'h01;
        @(negedge clk);
        chk("R7 k2 dot_idx", int'(dot_idx), 2);
        data_we = 1'b0; wdata = '0;
        for (int k = 3; k < 26; k++) begin
            @(negedge clk);
            if (k < 8) begin
                ei = k; ec = (k == 7) ? 1 : 0;
            end else begin
                ei = (k - 8) % 9; ec = (ei == 8) ? 1 : 0;
            end
            chk("R7 dot_idx", int'(dot_idx), ei);
            chk("R7 cclk_en", int'(cclk_en), ec);
        end
    endtask

    initial begin
        t_reset();
        t_regs();
        t_pattern("R3", 1'b0, 1'b0);
        t_pattern("R4", 1'b1, 1'b0);
        t_pattern("R5 half 8", 1'b0, 1'b1);
        t_pattern("R5 half 9", 1'b1, 1'b1);
        t_halt();
        t_release();
        t_midcell();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule